// File: doc/BRIEF.md
# Quantized Variable-Width Instruction Aligner

This block sits between a source of fixed-width instruction packets and the instruction register of a wide-issue processor. Packets are appended to a small prefetch store. The aligner reads the header of the oldest buffered instruction and works out how many 16-bit quanta the instruction occupies. It presents the instruction left-aligned on its output. Every instruction is a whole number of quanta wide, so each shift after a consume is a whole number of quanta.

Each instruction header carries a flag that marks the instruction as the last useful one in its packet. When that flag is set, the unused tail of the packet is dropped together with the instruction, and the next instruction starts on a packet boundary. A redirect input discards everything buffered and restarts the stream at a given quantum offset inside the next packet delivered. A target instruction that fits inside that first packet is ready after one fetch. A target that runs past the packet end needs exactly one more fetch.

Top module: `quanta_aligner`

## Requirements
- R1: After reset, `insn_valid_o` is low and `pkt_ready_o` is high.
- R2: Packet quanta enter the stream in order. Quantum k of a packet sits in bits [16k+15:16k], and k=0 comes first in the stream.
- R3: Header layout, in the first quantum of an instruction: bit 15 is the packet-end flag and bits 14:13 are the template code c. The instruction is c+1 quanta wide, and `insn_quanta_o` shows c+1.
- R4: `insn_data_o` holds the current instruction with its first quantum in bits [15:0] and quantum k in bits [16k+15:16k]. Valid is raised only once every quantum of the instruction is buffered.
- R5: After a handshake on an instruction whose flag is clear, the next instruction is the quantum that directly follows it.
- R6: After a handshake on an instruction whose flag is set, the next instruction starts at the following packet boundary. No quantum is dropped when the instruction already ends on a boundary.
- R7: A redirect discards all buffered quanta. The first packet accepted afterwards contributes only its quanta from the given offset onward. During the redirect cycle `pkt_ready_o` and `insn_valid_o` are low, and no instruction is consumed.
- R8: After a redirect, a target that fits inside its packet becomes valid after one accepted packet. A target that crosses the packet end becomes valid after exactly two.
- R9: `pkt_ready_o` is low whenever fewer than one packet's worth of quanta is free, so no quantum is lost.
- R10: While an instruction is valid but not accepted, and no redirect occurs, its header and width stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid_i | input | 1 | Packet offered |
| pkt_data_i | input | PKT_QUANTA*16 | Packet, quantum 0 in low bits |
| pkt_ready_o | output | 1 | Room for a whole packet |
| redir_valid_i | input | 1 | Redirect request |
| redir_qofs_i | input | log2(PKT_QUANTA) | Quantum offset of the target in its packet |
| insn_valid_o | output | 1 | Complete instruction at the output |
| insn_data_o | output | MAX_QUANTA*16 | Left-aligned instruction window |
| insn_quanta_o | output | log2(MAX_QUANTA+1) | Width of the current instruction in quanta |
| insn_ready_i | input | 1 | Consumer takes the instruction |

## Verification
The case of interest is a redirect arriving in the same cycle as a consumer that is ready and a buffer that holds a complete old-stream instruction. The bench forces `insn_ready_i` high exactly in the redirect cycle. A handshake in that cycle would pull an instruction the scoreboard never expected, or shift the expected stream. A second overlap is a consume and a packet append on the same edge, which happens throughout the runs because of the uneven ready and valid patterns. That overlap is judged by the scoreboard comparing every instruction quantum against a model of the packed program, including packet-end skips and packet-crossing targets.

// File: rtl/qalign_pkg.sv
package qalign_pkg;

    localparam int QUANTUM_W = 16;
    localparam int TSEL_W    = 2;

    typedef logic [QUANTUM_W-1:0] quantum_t;

    // Control bits at the top of an instruction's first quantum
    typedef struct packed {
        logic              eop;
        logic [TSEL_W-1:0] tsel;
    } ctl_t;

    function automatic int tmpl_quanta(input logic [TSEL_W-1:0] tsel);
        return int'(tsel) + 1;
    endfunction

    // Quanta left in the packet after a position that is end_pos quanta past its start
    function automatic int pad_to_packet(input int end_pos, input int pkt_q);
        int r;
        r = end_pos % pkt_q;
        return (r == 0) ? 0 : pkt_q - r;
    endfunction

endpackage

// File: rtl/qalign_head_dec.sv
module qalign_head_dec
    import qalign_pkg::*;
#(
    parameter int PKT_QUANTA = 4,
    parameter int CNT_W      = 4,
    parameter int OFS_W      = 2
) (
    input  ctl_t             ctl,
    input  logic [OFS_W-1:0] head_ofs,
    output logic [CNT_W-1:0] width,
    output logic             eop,
    output logic [CNT_W-1:0] step
);

    always_comb begin
        int w;
        int pad;
        w     = tmpl_quanta(ctl.tsel);
        pad   = ctl.eop ? pad_to_packet(int'(head_ofs) + w, PKT_QUANTA) : 0;
        width = CNT_W'(w);
        step  = CNT_W'(w + pad);
        eop   = ctl.eop;
    end

endmodule

// File: rtl/qalign_buf.sv
module qalign_buf
    import qalign_pkg::*;
#(
    parameter int PKT_QUANTA = 4,
    parameter int DEPTH_Q    = 12,
    parameter int OUT_Q      = 4,
    parameter int CNT_W      = 4,
    parameter int OFS_W      = 2,
    localparam int IDX_W     = $clog2(DEPTH_Q),
    localparam int PKT_W     = PKT_QUANTA * QUANTUM_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     flush,
    input  logic                     load,
    input  logic [PKT_W-1:0]         pkt,
    input  logic [OFS_W-1:0]         skip,
    input  logic [CNT_W-1:0]         drop,
    output logic [OUT_Q*QUANTUM_W-1:0] head,
    output logic [CNT_W-1:0]         count
);

    quantum_t         store_q [DEPTH_Q];
    quantum_t         next_q  [DEPTH_Q];
    quantum_t         pkt_q   [PKT_QUANTA];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    for (genvar k = 0; k < PKT_QUANTA; k++) begin : g_unpack
        assign pkt_q[k] = pkt[k*QUANTUM_W +: QUANTUM_W];
    end

    // Shift out the consumed quanta, then append the packet after the kept ones
    always_comb begin
        int keep;
        int src;
        int j;
        keep = int'(cnt_q) - int'(drop);
        for (int i = 0; i < DEPTH_Q; i++) begin
            next_q[i] = store_q[i];
            src = i + int'(drop);
            j   = i - keep + int'(skip);
            if (src < int'(cnt_q)) begin
                next_q[i] = store_q[IDX_W'(src)];
            end else if (load && i >= keep && j < PKT_QUANTA) begin
                next_q[i] = pkt_q[OFS_W'(j)];
            end
        end
        if (flush) begin
            cnt_d = '0;
        end else begin
            cnt_d = CNT_W'(keep + (load ? PKT_QUANTA - int'(skip) : 0));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH_Q; i++) begin
            store_q[i] <= next_q[i];
        end
    end

    for (genvar k = 0; k < OUT_Q; k++) begin : g_head
        assign head[k*QUANTUM_W +: QUANTUM_W] = store_q[k];
    end

    assign count = cnt_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        int'(cnt_q) <= DEPTH_Q); // R9

    AST_DROP_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        drop <= cnt_q); // R6

    AST_LOAD_HAS_ROOM: assert property (@(posedge clk) disable iff (rst)
        load |-> (int'(cnt_q) + PKT_QUANTA <= DEPTH_Q)); // R9

endmodule

// File: rtl/quanta_aligner.sv
module quanta_aligner
    import qalign_pkg::*;
#(
    parameter int PKT_QUANTA = 4,
    parameter int MAX_QUANTA = 4,
    localparam int DEPTH_Q   = 2 * PKT_QUANTA + MAX_QUANTA,
    localparam int CNT_W     = $clog2(DEPTH_Q + 1),
    localparam int OFS_W     = $clog2(PKT_QUANTA),
    localparam int LEN_W     = $clog2(MAX_QUANTA + 1),
    localparam int PKT_W     = PKT_QUANTA * QUANTUM_W,
    localparam int INSN_W    = MAX_QUANTA * QUANTUM_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pkt_valid_i,
    input  logic [PKT_W-1:0]  pkt_data_i,
    output logic              pkt_ready_o,
    input  logic              redir_valid_i,
    input  logic [OFS_W-1:0]  redir_qofs_i,
    output logic              insn_valid_o,
    output logic [INSN_W-1:0] insn_data_o,
    output logic [LEN_W-1:0]  insn_quanta_o,
    input  logic              insn_ready_i
);

    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] width;
    logic [CNT_W-1:0] step;
    logic [CNT_W-1:0] drop;
    logic             eop;
    logic             load;
    logic             consume;
    logic [OFS_W-1:0] head_ofs_q;
    logic [OFS_W-1:0] skip_ofs_q;
    logic             skip_pend_q;
    logic [OFS_W-1:0] skip;

    // Redirect wins over both fill and consume in its cycle
    assign pkt_ready_o  = !redir_valid_i && (int'(count) <= DEPTH_Q - PKT_QUANTA);
    assign load         = pkt_valid_i && pkt_ready_o;
    assign insn_valid_o = !redir_valid_i && (count >= width);
    assign consume      = insn_valid_o && insn_ready_i;
    assign drop         = consume ? step : '0;
    assign skip         = skip_pend_q ? skip_ofs_q : '0;
    assign insn_quanta_o = LEN_W'(width);

    qalign_buf #(
        .PKT_QUANTA (PKT_QUANTA),
        .DEPTH_Q    (DEPTH_Q),
        .OUT_Q      (MAX_QUANTA),
        .CNT_W      (CNT_W),
        .OFS_W      (OFS_W)
    ) u_buf (
        .clk   (clk),
        .rst   (rst),
        .flush (redir_valid_i),
        .load  (load),
        .pkt   (pkt_data_i),
        .skip  (skip),
        .drop  (drop),
        .head  (insn_data_o),
        .count (count)
    );

    qalign_head_dec #(
        .PKT_QUANTA (PKT_QUANTA),
        .CNT_W      (CNT_W),
        .OFS_W      (OFS_W)
    ) u_dec (
        .ctl      (ctl_t'(insn_data_o[QUANTUM_W-1 -: TSEL_W+1])),
        .head_ofs (head_ofs_q),
        .width    (width),
        .eop      (eop),
        .step     (step)
    );

    // Position of the buffer head inside its packet, and the pending target offset
    always_ff @(posedge clk) begin
        if (rst) begin
            head_ofs_q  <= '0;
            skip_ofs_q  <= '0;
            skip_pend_q <= 1'b0;
        end else if (redir_valid_i) begin
            head_ofs_q  <= redir_qofs_i;
            skip_ofs_q  <= redir_qofs_i;
            skip_pend_q <= 1'b1;
        end else begin
            if (load) begin
                skip_pend_q <= 1'b0;
            end
            if (consume) begin
                head_ofs_q <= OFS_W'((int'(head_ofs_q) + int'(step)) % PKT_QUANTA);
            end
        end
    end

    AST_REDIR_FLUSH: assert property (@(posedge clk) disable iff (rst)
        redir_valid_i |=> (count == '0)); // R7

    AST_EOP_REALIGN: assert property (@(posedge clk) disable iff (rst)
        (consume && eop) |=> (head_ofs_q == '0)); // R6

    AST_HOLD_HEAD: assert property (@(posedge clk) disable iff (rst)
        (insn_valid_o && !insn_ready_i && !redir_valid_i) |=>
            ($stable(insn_data_o[QUANTUM_W-1:0]) && $stable(insn_quanta_o))); // R10

    AST_SKIP_ONCE: assert property (@(posedge clk) disable iff (rst)
        (load && !redir_valid_i) |=> !skip_pend_q); // R7

endmodule

// File: tb/quanta_aligner_bench.sv
module quanta_aligner_bench;

    localparam int PKTQ = 4;
    localparam int MAXQ = 4;
    localparam int MEMQ = 512;
    localparam int NMAX = 200;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pkt_valid_i;
    logic [63:0] pkt_data_i;
    logic        pkt_ready_o;
    logic        redir_valid_i;
    logic [1:0]  redir_qofs_i;
    logic        insn_valid_o;
    logic [63:0] insn_data_o;
    logic [2:0]  insn_quanta_o;
    logic        insn_ready_i;

    always #2 clk = ~clk;

    quanta_aligner #(.PKT_QUANTA(PKTQ), .MAX_QUANTA(MAXQ)) u_quanta_aligner (
        .clk           (clk),
        .rst           (rst),
        .pkt_valid_i   (pkt_valid_i),
        .pkt_data_i    (pkt_data_i),
        .pkt_ready_o   (pkt_ready_o),
        .redir_valid_i (redir_valid_i),
        .redir_qofs_i  (redir_qofs_i),
        .insn_valid_o  (insn_valid_o),
        .insn_data_o   (insn_data_o),
        .insn_quanta_o (insn_quanta_o),
        .insn_ready_i  (insn_ready_i)
    );

    logic [15:0] mem [MEMQ];
    int          ins_addr [NMAX];
    int          ins_w    [NMAX];
    bit          ins_after_eop [NMAX];
    int          nins;
    int          q_exp [$];
    int          checks = 0;
    int          fails  = 0;
    bit          redir_req = 0;
    bit          coll_req  = 0;
    bit          started   = 0;
    bit          done      = 0;
    bit          first_pend = 0;
    int          redir_target = 0;
    int          exp_fetch = 1;
    int          fetch_cnt = 0;
    bit          acc_pkt = 0;
    bit          acc_insn = 0;
    logic [63:0] cap_data = '0;
    logic [2:0]  cap_len = '0;
    int          pkt_ptr = 0;
    int          cyc = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] pkt_at(input int p);
        logic [63:0] v;
        for (int k = 0; k < PKTQ; k++) begin
            int a;
            a = p * PKTQ + k;
            v[k*16 +: 16] = (a < MEMQ) ? mem[a] : 16'h0;
        end
        return v;
    endfunction

    // Lay out a program of variable-width instructions with packet-end skips
    task automatic build_program();
        int a;
        int s;
        bit prev_eop;
        a = 0;
        s = 12345;
        prev_eop = 0;
        nins = 0;
        for (int i = 0; i < MEMQ; i++) mem[i] = 16'h0;
        while (a < MEMQ - 8 && nins < NMAX) begin
            int w;
            bit e;
            s = s * 1103515245 + 12345;
            w = 1 + ((s >>> 16) & 3);
            e = (nins % 5 == 3);
            ins_addr[nins] = a;
            ins_w[nins] = w;
            ins_after_eop[nins] = prev_eop;
            mem[a] = {e, 2'(w - 1), 13'(nins)};
            for (int k = 1; k < w; k++) mem[a + k] = 16'(nins * 41 + k * 4099 + 14848);
            a = a + w;
            if (e) a = ((a + PKTQ - 1) / PKTQ) * PKTQ;
            prev_eop = e;
            nins++;
        end
    endtask

    always @(posedge clk) begin
        acc_pkt  <= pkt_valid_i && pkt_ready_o;
        acc_insn <= insn_valid_o && insn_ready_i;
        cap_data <= insn_data_o;
        cap_len  <= insn_quanta_o;
        cyc      <= cyc + 1;
        if (redir_valid_i) fetch_cnt <= 0;
        else if (pkt_valid_i && pkt_ready_o) fetch_cnt <= fetch_cnt + 1;
    end

    // Packet source and redirect driver
    initial begin
        pkt_valid_i = 1'b0;
        pkt_data_i = '0;
        redir_valid_i = 1'b0;
        redir_qofs_i = '0;
        wait (!rst);
        forever begin
            @(negedge clk);
            if (redir_req) begin
                pkt_ptr = redir_target / PKTQ;
                redir_qofs_i = 2'(redir_target % PKTQ);
                redir_valid_i = 1'b1;
                redir_req = 0;
                started = 1;
            end else begin
                redir_valid_i = 1'b0;
                if (acc_pkt) pkt_ptr++;
            end
            pkt_valid_i = started && (cyc % 7 != 5);
            pkt_data_i = pkt_at(pkt_ptr);
        end
    end

    // Monitor: scoreboard compare and consumer
    initial begin
        bit          prev_hold;
        logic [15:0] prev_hdr;
        logic [2:0]  prev_len;
        prev_hold = 0;
        prev_hdr = '0;
        prev_len = '0;
        insn_ready_i = 1'b0;
        wait (!rst);
        forever begin
            bit rdy;
            @(negedge clk);
            #1;
            if (acc_insn) begin
                if (q_exp.size() == 0) begin
                    check(0, "R7", "unexpected instruction hdr", int'(cap_data[15:0]), 0);
                end else begin
                    int idx;
                    bit ok;
                    string req;
                    idx = q_exp.pop_front();
                    check(int'(cap_len) == ins_w[idx], "R3", "width",
                          int'(cap_len), ins_w[idx]);
                    ok = 1;
                    for (int k = 0; k < ins_w[idx]; k++)
                        if (cap_data[k*16 +: 16] !== mem[ins_addr[idx] + k]) ok = 0;
                    req = ins_after_eop[idx] ? "R6" : "R5";
                    // data layout per R4, packet order per R2
                    check(ok, req, "data (R4 alignment, R2 order) hdr",
                          int'(cap_data[15:0]), int'(mem[ins_addr[idx]]));
                end
            end
            if (redir_valid_i) begin
                check(!insn_valid_o && !pkt_ready_o, "R7", "valid/ready in redirect cycle",
                      int'({insn_valid_o, pkt_ready_o}), 0);
                first_pend = 1;
                prev_hold = 0;
            end else begin
                if (prev_hold) begin
                    check(insn_valid_o && insn_data_o[15:0] == prev_hdr && insn_quanta_o == prev_len,
                          "R10", "held header", int'(insn_data_o[15:0]), int'(prev_hdr));
                end
                if (first_pend && insn_valid_o) begin
                    check(fetch_cnt == exp_fetch, "R8", "fetches before target valid",
                          fetch_cnt, exp_fetch);
                    first_pend = 0;
                end
            end
            if (coll_req && redir_valid_i) begin
                rdy = 1;
                coll_req = 0;
            end else begin
                rdy = (q_exp.size() > 0) && (cyc % 3 != 2);
            end
            prev_hold = insn_valid_o && !rdy && !redir_valid_i;
            prev_hdr = insn_data_o[15:0];
            prev_len = insn_quanta_o;
            insn_ready_i = rdy;
        end
    end

    task automatic run_seg(input int start, input int n, input bit coll);
        int last;
        while (q_exp.size() > 0) @(negedge clk);
        exp_fetch = ((ins_addr[start] % PKTQ) + ins_w[start] > PKTQ) ? 2 : 1;
        @(negedge clk);
        #1;
        redir_target = ins_addr[start];
        coll_req = coll;
        redir_req = 1;
        @(negedge clk);
        #2;
        last = (start + n < nins) ? start + n : nins;
        for (int i = start; i < last; i++) q_exp.push_back(i);
        while (q_exp.size() > 0) @(negedge clk);
        repeat (8) @(negedge clk);
        #2;
        check(!pkt_ready_o, "R9", "ready with full buffer", int'(pkt_ready_o), 0);
    endtask

    initial begin
        int s_idx;
        int n_idx;
        int e_idx;
        build_program();
        s_idx = 1;
        n_idx = 1;
        e_idx = 1;
        for (int i = nins - 1; i >= 1; i--) begin
            if ((ins_addr[i] % PKTQ) + ins_w[i] > PKTQ) s_idx = i;
            if ((ins_addr[i] % PKTQ) != 0 && (ins_addr[i] % PKTQ) + ins_w[i] <= PKTQ) n_idx = i;
            if (i >= 10 && ins_after_eop[i]) e_idx = i;
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        #2;
        check(!insn_valid_o && pkt_ready_o, "R1", "reset valid/ready",
              int'({insn_valid_o, pkt_ready_o}), 1);
        run_seg(0, 60, 0);
        run_seg(s_idx, 20, 0);
        run_seg(n_idx, 20, 1);
        run_seg(e_idx, 30, 0);
        run_seg(s_idx + 1, 25, 1);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule